// File: doc/BRIEF.md
# RTC Tick Prescaler

This block turns a slow reference clock into the timing strobes a real-time clock consumes. A two-bit select tells it which of three reference rates is connected: 32768 Hz, 32000 Hz or 38400 Hz. A base divider turns that reference into a 512 Hz strobe. A binary chain below the base divider makes the slower power-of-two strobes down to 2 Hz and a separate 1 Hz strobe that advances the seconds count.

The 32000 Hz rate is not a whole multiple of 512. For that rate the base divider alternates its period between 62 and 63 reference cycles, which gives an exact 512 Hz average. A run enable gates all counting. Changing the select restarts the whole chain from zero, so a new rate never inherits a partial count from the old one. Every strobe is a single reference-clock cycle wide.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: With `freq_sel` = 0 the 512 Hz strobe (`tick_pow2[8]`) recurs every 64 reference cycles. With `freq_sel` = 2 it recurs every 75 cycles.
- R2: With `freq_sel` = 1 the base period alternates 62, 63, 62, 63, ... cycles. The first period after a restart is 62.
- R3: Every strobe output is high for exactly one reference cycle at a time.
- R4: `tick_pow2[i]` is a strobe at 2^(i+1) Hz. It fires together with every 2^(8-i)-th 512 Hz strobe after a restart, so bit 8 is the 512 Hz strobe itself and bit 0 is 2 Hz.
- R5: `tick_1hz` fires together with every 512th 512 Hz strobe after a restart, and all `tick_pow2` bits are high in that cycle.
- R6: While `run_en` is low, all counters are held at zero and no strobe fires. After `run_en` rises, the first 512 Hz strobe comes one full base period later, counted from the first clock edge that sees the enable.
- R7: A change of `freq_sel` restarts the chain. No strobe fires in the cycle after the change, and the first strobe comes one full new base period after the restart edge.
- R8: While reset is asserted, all strobe outputs are low.
- R9: Select value 3 behaves exactly like value 0: the base period is 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (one of the three supported rates) |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 2 | Reference rate: 0 = 32768 Hz, 1 = 32000 Hz, 2 = 38400 Hz, 3 = same as 0 |
| run_en | input | 1 | Counting enable; low holds the chain at zero |
| tick_1hz | output | 1 | One-cycle 1 Hz strobe |
| tick_pow2 | output | 9 | One-cycle strobes; bit i is 2^(i+1) Hz |

## Verification
The hardest event to reach is the 1 Hz strobe. It needs 512 full base periods, which at the 32768 Hz setting is 32768 reference cycles without any restart. The stimulus therefore holds one long uninterrupted run at select 0. Over that run it counts every strobe bit and checks the single 1 Hz event at its exact cycle. Shorter runs then switch the select mid-count and drop the enable mid-period. These runs place each restart at a known cycle, so the first strobe after it can be timed exactly and the 62-first ordering of the alternating divider can be seen.

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
  parameter int SUB_W       = 9,
  parameter int DIV_32K     = 64,
  parameter int DIV_32K0_LO = 62,
  parameter int DIV_38K     = 75
)(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [1:0]       freq_sel,
  input  logic             run_en,
  output logic             tick_1hz,
  output logic [SUB_W-1:0] tick_pow2
);

  localparam int DIV_HI  = DIV_32K0_LO + 1;
  localparam int MAX_AB  = (DIV_32K > DIV_HI) ? DIV_32K : DIV_HI;
  localparam int DIV_MAX = (DIV_38K > MAX_AB) ? DIV_38K : MAX_AB;
  localparam int BASE_W  = $clog2(DIV_MAX);

  localparam logic [BASE_W-1:0] LAST_A  = BASE_W'(DIV_32K - 1);
  localparam logic [BASE_W-1:0] LAST_B0 = BASE_W'(DIV_32K0_LO - 1);
  localparam logic [BASE_W-1:0] LAST_B1 = BASE_W'(DIV_HI - 1);
  localparam logic [BASE_W-1:0] LAST_C  = BASE_W'(DIV_38K - 1);

  logic [BASE_W-1:0] base_cnt;
  logic [BASE_W-1:0] last_cnt;
  logic [SUB_W-1:0]  sub_cnt;
  logic [SUB_W-1:0]  pow2_hit;
  logic [1:0]        sel_q;
  logic              odd_q;
  logic              restart;
  logic              base_hit;
  logic              one_hit;

  always_comb begin
    case (freq_sel)
      2'd1:    last_cnt = odd_q ? LAST_B1 : LAST_B0;
      2'd2:    last_cnt = LAST_C;
      default: last_cnt = LAST_A;
    endcase
  end

  assign restart  = !run_en || (freq_sel != sel_q);
  assign base_hit = !restart && (base_cnt == last_cnt);
  assign one_hit  = base_hit && (&sub_cnt);

  for (genvar i = 0; i < SUB_W; i++) begin : g_tap
    localparam logic [SUB_W-1:0] MASK = SUB_W'((1 << (SUB_W - 1 - i)) - 1);
    assign pow2_hit[i] = base_hit && ((sub_cnt & MASK) == MASK);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 2'd0;
      base_cnt  <= '0;
      sub_cnt   <= '0;
      odd_q     <= 1'b0;
      tick_1hz  <= 1'b0;
      tick_pow2 <= '0;
    end else begin
      sel_q     <= freq_sel;
      tick_1hz  <= one_hit;
      tick_pow2 <= pow2_hit;
      if (restart) begin
        base_cnt <= '0;
        sub_cnt  <= '0;
        odd_q    <= 1'b0;
      end else if (base_hit) begin
        base_cnt <= '0;
        sub_cnt  <= sub_cnt + 1'b1;
        odd_q    <= !odd_q;
      end else begin
        base_cnt <= base_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_tick_prescaler_chk.sv
module rtc_tick_prescaler_chk #(
  parameter int SUB_W   = 9,
  parameter int MIN_GAP = 62
)(
  input logic             clk_ref,
  input logic             rst_n,
  input logic [1:0]       freq_sel,
  input logic             run_en,
  input logic             tick_1hz,
  input logic [SUB_W-1:0] tick_pow2
);

  localparam logic [SUB_W-1:0] BELOW_TOP = {1'b0, {(SUB_W-1){1'b1}}};

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick_pow2[SUB_W-1]) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  p_one_cycle_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tick_1hz || (|tick_pow2)) |=> (!tick_1hz && tick_pow2 == '0));

  p_min_gap_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tick_pow2[SUB_W-1] && seen) |-> (gap >= 16'(MIN_GAP - 1)));

  p_nested_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ((tick_pow2 & ~(tick_pow2 >> 1)) & BELOW_TOP) == '0);

  p_second_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick_1hz |-> (&tick_pow2));

  p_hold_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run_en |=> (!tick_1hz && tick_pow2 == '0));

  p_restart_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (freq_sel != $past(freq_sel)) |=> (!tick_1hz && tick_pow2 == '0));

endmodule

bind rtc_tick_prescaler rtc_tick_prescaler_chk #(
  .SUB_W(SUB_W),
  .MIN_GAP(DIV_32K0_LO)
) chk_i (
  .clk_ref(clk_ref),
  .rst_n(rst_n),
  .freq_sel(freq_sel),
  .run_en(run_en),
  .tick_1hz(tick_1hz),
  .tick_pow2(tick_pow2)
);

// File: tb/rtc_tick_prescaler_tb_top.sv
`timescale 1ns/1ps
module rtc_tick_prescaler_tb_top;
  localparam int SW = 9;

  logic          clk_ref = 1'b0;
  logic          rst_n;
  logic [1:0]    freq_sel;
  logic          run_en;
  logic          tick_1hz;
  logic [SW-1:0] tick_pow2;

  always #2 clk_ref = !clk_ref;

  rtc_tick_prescaler dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .freq_sel(freq_sel), .run_en(run_en),
    .tick_1hz(tick_1hz), .tick_pow2(tick_pow2)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R8";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  longint cyc = 0;
  int m_cnt, m_sub, m_prev;
  bit m_odd;
  bit e_1hz;
  bit [SW-1:0] e_pow2;

  always @(posedge clk_ref) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_sub = 0; m_odd = 0; m_prev = 0; e_1hz = 0; e_pow2 = '0;
    end else begin
      int sel, period;
      bit changed;
      sel = int'(freq_sel);
      changed = (sel != m_prev);
      m_prev = sel;
      e_1hz = 0;
      e_pow2 = '0;
      if (!run_en || changed) begin
        m_cnt = 0; m_sub = 0; m_odd = 0;
      end else begin
        if (sel == 2)      period = 75;
        else if (sel == 1) period = m_odd ? 63 : 62;
        else               period = 64;
        if (m_cnt == period - 1) begin
          m_cnt = 0;
          for (int i = 0; i < SW; i++)
            e_pow2[i] = ((m_sub + 1) % (1 << (SW - 1 - i))) == 0;
          e_1hz = ((m_sub + 1) % 512) == 0;
          m_sub = (m_sub + 1) % 512;
          m_odd = !m_odd;
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // Monitor and per-cycle comparison
  longint tq[$];
  longint hq[$];
  int pc[SW];
  int dbl = 0;
  bit prev_any = 0;

  always @(negedge clk_ref) begin
    if (cyc > 0 && rst_n) begin
      chk({tick_1hz, tick_pow2} == {e_1hz, e_pow2}, cur_req, "strobes vs model",
          longint'({tick_1hz, tick_pow2}), longint'({e_1hz, e_pow2}));
    end
    if (tick_pow2[SW-1]) tq.push_back(cyc);
    if (tick_1hz) hq.push_back(cyc);
    for (int i = 0; i < SW; i++) if (tick_pow2[i]) pc[i]++;
    if (prev_any && (tick_1hz || (|tick_pow2))) dbl++;
    prev_any = tick_1hz || (|tick_pow2);
  end

  task automatic clear_mon();
    tq.delete();
    hq.delete();
    for (int i = 0; i < SW; i++) pc[i] = 0;
  endtask

  task automatic check_gaps(input string req, input int ga, input int gb);
    int bad = 0;
    for (int k = 0; k + 1 < tq.size(); k++)
      if (tq[k+1] - tq[k] != ((k % 2 == 0) ? ga : gb)) bad++;
    chk(bad == 0, req, "base gaps off pattern", bad, 0);
    chk(tq.size() > 4, req, "base strobe count", tq.size(), 5);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    longint c0;
    rst_n = 1'b0; freq_sel = 2'd0; run_en = 1'b0;
    repeat (5) @(negedge clk_ref);
    chk({tick_1hz, tick_pow2} == '0, "R8", "outputs in reset",
        longint'({tick_1hz, tick_pow2}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);

    // R6/R1/R4/R5: long run at select 0
    cur_req = "R5";
    clear_mon();
    c0 = cyc; run_en = 1'b1;
    repeat (33000) @(negedge clk_ref);
    chk(tq.size() > 0 && tq[0] - c0 == 64, "R6", "first strobe after enable",
        tq.size() > 0 ? tq[0] - c0 : -1, 64);
    check_gaps("R1", 64, 64);
    chk(hq.size() == 1, "R5", "1 Hz count", hq.size(), 1);
    chk(hq.size() > 0 && hq[0] - c0 == 32768, "R5", "1 Hz cycle",
        hq.size() > 0 ? hq[0] - c0 : -1, 32768);
    for (int i = 0; i < SW; i++)
      chk(pc[i] == tq.size() / (1 << (SW - 1 - i)), "R4", $sformatf("bit %0d count", i),
          pc[i], tq.size() / (1 << (SW - 1 - i)));

    // R9: select 3 mid-count
    cur_req = "R9";
    repeat (17) @(negedge clk_ref);
    clear_mon();
    c0 = cyc; freq_sel = 2'd3;
    repeat (1500) @(negedge clk_ref);
    chk(tq.size() > 0 && tq[0] - c0 == 65, "R9", "first strobe after select 3",
        tq.size() > 0 ? tq[0] - c0 : -1, 65);
    check_gaps("R9", 64, 64);

    // R7/R1: select 2 mid-count
    cur_req = "R7";
    repeat (29) @(negedge clk_ref);
    clear_mon();
    c0 = cyc; freq_sel = 2'd2;
    repeat (2000) @(negedge clk_ref);
    chk(tq.size() > 0 && tq[0] - c0 == 76, "R7", "first strobe after select 2",
        tq.size() > 0 ? tq[0] - c0 : -1, 76);
    check_gaps("R1", 75, 75);

    // R2: select 1 alternates 62, 63
    cur_req = "R2";
    repeat (11) @(negedge clk_ref);
    clear_mon();
    c0 = cyc; freq_sel = 2'd1;
    repeat (3000) @(negedge clk_ref);
    chk(tq.size() > 0 && tq[0] - c0 == 63, "R2", "first strobe after select 1",
        tq.size() > 0 ? tq[0] - c0 : -1, 63);
    check_gaps("R2", 63, 62);

    // R6: enable low mid-period, then back on
    cur_req = "R6";
    repeat (40) @(negedge clk_ref);
    clear_mon();
    run_en = 1'b0;
    repeat (200) @(negedge clk_ref);
    chk(tq.size() == 0 && hq.size() == 0, "R6", "strobes while disabled", tq.size(), 0);
    freq_sel = 2'd0;
    repeat (3) @(negedge clk_ref);
    clear_mon();
    c0 = cyc; run_en = 1'b1;
    repeat (300) @(negedge clk_ref);
    chk(tq.size() > 0 && tq[0] - c0 == 64, "R6", "first strobe after re-enable",
        tq.size() > 0 ? tq[0] - c0 : -1, 64);

    chk(dbl == 0, "R3", "strobes high two cycles in a row", dbl, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule